// File: doc/BRIEF.md
# Defective Pixel Patch-Up Sequencer

This block repairs a known list of bad sensor sites in a raw pixel stream. Before each frame it fetches a table of defect coordinates from external memory through a simple read port and keeps a few entries ready in a small prefetch queue. Every pixel carries a row and column derived from the frame and line markers. When the pixel at the repair point matches the queued entry at the head, the block replaces its value with an estimate built from its same-colour horizontal neighbours and moves on to the next entry.

The enable bit, the defect count and the table base are sampled when the block leaves reset and again each time a frame end leaves the repair point. Their values therefore govern the next frame. If an entry is still needed but the queue is empty when a pixel reaches the repair point, the block raises an error flag. It then stops reading and repairing for the rest of that frame. The flag drops with the frame end, and the following frame is armed again.

Pixels within a line must arrive on consecutive cycles. Gaps are allowed only between lines.

Top module: `pixfix_top`

## Requirements
- R1: With the enable bit low when the configuration is sampled (at reset exit and after each frame end), the following frame passes through unchanged and no table reads are issued.
- R2: Per frame, exactly the sampled count of table words is requested, and only the first count defects of the table are repaired.
- R3: The first read address of a frame is the base address with its low 6 bits forced to zero. Each further read is 4 bytes higher, and read addresses always have bits [1:0] equal to zero.
- R4: A table word holds the row in bits [31:16] and the column in bits [15:0]. A matching pixel with both neighbours available becomes floor((P[c-2] + P[c+2]) / 2), using the raw neighbour values. All other pixels are unchanged.
- R5: At a line edge, where column-2 is below 0 or column+2 is past the line end, the one available neighbour is copied.
- R6: Every output, including valid and the four markers, appears exactly 3 clock edges after the matching input. After reset the outputs are invalid and the error flag is 0.
- R7: At most 4 table words are buffered or in flight at once, so with a count above 4 exactly 4 reads are accepted before the frame starts.
- R8: When an entry is still due and the prefetch queue is empty as a pixel reaches the repair point, errStatus goes high with that pixel's output, and rdReq stays low while errStatus is high.
- R9: After the error, no pixel of that frame is repaired.
- R10: errStatus returns to 0 together with the output of the frame-end pixel, and the next frame is repaired normally again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgEnable | input | 1 | Repair enable, sampled at arm time |
| cfgCount | input | CNT_W (15) | Number of table entries for the next frame |
| cfgBase | input | ADDR_W (32) | Table byte address; low 6 bits ignored |
| inValid | input | 1 | Input pixel valid |
| inPix | input | PIX_W (10) | Input pixel value |
| inFrameStart | input | 1 | First pixel of a frame |
| inLineStart | input | 1 | First pixel of a line |
| inLineEnd | input | 1 | Last pixel of a line |
| inFrameEnd | input | 1 | Last pixel of a frame |
| rdReq | output | 1 | Read request |
| rdAddr | output | ADDR_W (32) | Read byte address |
| rdReady | input | 1 | Request accepted when high together with rdReq |
| rdValid | input | 1 | Read data valid, in request order |
| rdData | input | 32 | Table word |
| outValid | output | 1 | Output pixel valid |
| outPix | output | PIX_W (10) | Output pixel value |
| outFrameStart | output | 1 | Delayed frame start marker |
| outLineStart | output | 1 | Delayed line start marker |
| outLineEnd | output | 1 | Delayed line end marker |
| outFrameEnd | output | 1 | Delayed frame end marker |
| errStatus | output | 1 | Late-fetch error for the current frame |

## Verification
The hardest state to reach is the late-fetch error. It only occurs when the queue is empty while entries remain due, and a well-fed read port always keeps the queue ahead of the stream. The stimulus drops rdReady before the previous frame ends, so the arm that follows cannot fetch anything. The first pixel of the next frame then finds the queue empty. rdReady is raised again only after that frame drains, which shows both that the error lasts the whole frame and that repair resumes in the next one.

// File: rtl/pixfix_pkg.sv
package pixfix_pkg;
  localparam int COORD_W = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic fixPixel;
  } ctrlStrobeT;

  // pixel at the repair point, seen by control
  typedef struct packed {
    logic               valid;
    logic               frameEnd;
    logic [COORD_W-1:0] row;
    logic [COORD_W-1:0] col;
  } centreInfoT;
endpackage

// File: rtl/pixfix_datapath.sv
module pixfix_datapath
  import pixfix_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [PIX_W-1:0] inPix,
  input  logic             inFrameStart,
  input  logic             inLineStart,
  input  logic             inLineEnd,
  input  logic             inFrameEnd,
  input  ctrlStrobeT       strobe,
  output centreInfoT       centre,
  output logic             outValid,
  output logic [PIX_W-1:0] outPix,
  output logic             outFrameStart,
  output logic             outLineStart,
  output logic             outLineEnd,
  output logic             outFrameEnd
);
  localparam int RIGHT_REACH = 2;  // register stages up to the repair point
  localparam int LEFT_REACH  = 2;  // history behind the repair point

  typedef struct packed {
    logic               valid;
    logic               fs;
    logic               ls;
    logic               le;
    logic               fe;
    logic [COORD_W-1:0] row;
    logic [COORD_W-1:0] col;
    logic [PIX_W-1:0]   pix;
  } stageT;

  logic [COORD_W-1:0] rowReg, colReg, curRow, curCol;
  stageT              stage   [RIGHT_REACH];
  logic [PIX_W-1:0]   leftTap [LEFT_REACH];
  stageT              mid;
  logic               hasLeft, hasRight;
  logic [PIX_W:0]     pairSum;
  logic [PIX_W-1:0]   fixedPix;

  always_comb begin
    curCol = inLineStart ? '0 : colReg;
    if (inFrameStart)     curRow = '0;
    else if (inLineStart) curRow = rowReg + COORD_W'(1);
    else                  curRow = rowReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg <= '0;
      colReg <= '0;
    end else if (inValid) begin
      rowReg <= curRow;
      colReg <= curCol + COORD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RIGHT_REACH; i++) stage[i] <= '0;
      for (int i = 0; i < LEFT_REACH; i++)  leftTap[i] <= '0;
    end else begin
      stage[0] <= '{valid: inValid, fs: inFrameStart, ls: inLineStart, le: inLineEnd,
                    fe: inFrameEnd, row: curRow, col: curCol, pix: inPix};
      for (int i = 1; i < RIGHT_REACH; i++) stage[i] <= stage[i-1];
      leftTap[0] <= stage[RIGHT_REACH-1].pix;
      for (int i = 1; i < LEFT_REACH; i++) leftTap[i] <= leftTap[i-1];
    end
  end

  assign mid = stage[RIGHT_REACH-1];

  always_comb begin
    hasLeft  = mid.col >= COORD_W'(LEFT_REACH);
    hasRight = !mid.le && !stage[0].le && stage[0].valid && inValid;
    pairSum  = {1'b0, leftTap[LEFT_REACH-1]} + {1'b0, inPix};
    case ({hasLeft, hasRight})
      2'b11:   fixedPix = pairSum[PIX_W:1];
      2'b10:   fixedPix = leftTap[LEFT_REACH-1];
      2'b01:   fixedPix = inPix;
      default: fixedPix = mid.pix;
    endcase
  end

  assign centre = '{valid: mid.valid, frameEnd: mid.fe, row: mid.row, col: mid.col};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      outPix        <= '0;
      outFrameStart <= 1'b0;
      outLineStart  <= 1'b0;
      outLineEnd    <= 1'b0;
      outFrameEnd   <= 1'b0;
    end else begin
      outValid      <= mid.valid;
      outPix        <= strobe.fixPixel ? fixedPix : mid.pix;
      outFrameStart <= mid.fs;
      outLineStart  <= mid.ls;
      outLineEnd    <= mid.le;
      outFrameEnd   <= mid.fe;
    end
  end
endmodule

// File: rtl/pixfix_ctrl.sv
module pixfix_ctrl
  import pixfix_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 15,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [ADDR_W-1:0] cfgBase,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdReady,
  input  logic              rdValid,
  input  logic [31:0]       rdData,
  input  centreInfoT        centre,
  output ctrlStrobeT        strobe,
  output logic              errStatus
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(63);

  logic [31:0]       fifoMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  fifoCount, inflight;
  logic [LVL_W:0]    level;
  logic [CNT_W-1:0]  reqLeft, useLeft;
  logic [ADDR_W-1:0] addrReg;
  logic              frameOn, errFlag, armPending;
  logic [31:0]       head;
  logic              live, headHit, starve, accept, frameDone, armNow;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    head      = fifoMem[rdPtr];
    live      = centre.valid && frameOn && !errFlag;
    headHit   = live && (fifoCount != '0) &&
                (head[31:16] == centre.row) && (head[15:0] == centre.col);
    starve    = live && (useLeft != '0) && (fifoCount == '0);
    level     = {1'b0, fifoCount} + {1'b0, inflight};
    rdReq     = (reqLeft != '0) && (level < (LVL_W+1)'(DEPTH)) && !armPending && !errFlag;
    accept    = rdReq && rdReady;
    frameDone = centre.valid && centre.frameEnd;
    armNow    = armPending && (inflight == '0) && !rdValid;
  end

  assign rdAddr          = addrReg;
  assign errStatus       = errFlag;
  assign strobe.fixPixel = headHit;

  always_ff @(posedge clk) begin
    if (rdValid) fifoMem[wrPtr] <= rdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      fifoCount  <= '0;
      inflight   <= '0;
      reqLeft    <= '0;
      useLeft    <= '0;
      addrReg    <= '0;
      frameOn    <= 1'b0;
      errFlag    <= 1'b0;
      armPending <= 1'b1;
    end else begin
      inflight <= inflight + LVL_W'(accept) - LVL_W'(rdValid);
      errFlag  <= frameDone ? 1'b0 : (errFlag | starve);
      if (armNow) begin
        wrPtr      <= '0;
        rdPtr      <= '0;
        fifoCount  <= '0;
        reqLeft    <= cfgEnable ? cfgCount : '0;
        useLeft    <= cfgEnable ? cfgCount : '0;
        addrReg    <= cfgBase & ALIGN_MASK;
        frameOn    <= cfgEnable;
        armPending <= 1'b0;
      end else begin
        if (rdValid) wrPtr <= stepPtr(wrPtr);
        if (headHit) rdPtr <= stepPtr(rdPtr);
        fifoCount <= fifoCount + LVL_W'(rdValid) - LVL_W'(headHit);
        if (starve)      reqLeft <= '0;
        else if (accept) reqLeft <= reqLeft - CNT_W'(1);
        if (accept)  addrReg <= addrReg + ADDR_W'(4);
        if (headHit) useLeft <= useLeft - CNT_W'(1);
        if (frameDone) begin
          armPending <= 1'b1;
          frameOn    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pixfix_top.sv
module pixfix_top
  import pixfix_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 15,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic              inValid,
  input  logic [PIX_W-1:0]  inPix,
  input  logic              inFrameStart,
  input  logic              inLineStart,
  input  logic              inLineEnd,
  input  logic              inFrameEnd,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdReady,
  input  logic              rdValid,
  input  logic [31:0]       rdData,
  output logic              outValid,
  output logic [PIX_W-1:0]  outPix,
  output logic              outFrameStart,
  output logic              outLineStart,
  output logic              outLineEnd,
  output logic              outFrameEnd,
  output logic              errStatus
);
  ctrlStrobeT strobe;
  centreInfoT centre;

  pixfix_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgCount(cfgCount), .cfgBase(cfgBase),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdReady(rdReady), .rdValid(rdValid), .rdData(rdData),
    .centre(centre), .strobe(strobe), .errStatus(errStatus)
  );

  pixfix_datapath #(.PIX_W(PIX_W)) uPath (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPix(inPix),
    .inFrameStart(inFrameStart), .inLineStart(inLineStart),
    .inLineEnd(inLineEnd), .inFrameEnd(inFrameEnd),
    .strobe(strobe), .centre(centre),
    .outValid(outValid), .outPix(outPix), .outFrameStart(outFrameStart),
    .outLineStart(outLineStart), .outLineEnd(outLineEnd), .outFrameEnd(outFrameEnd)
  );
endmodule

// File: rtl/pixfix_checker.sv
module pixfix_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              errStatus,
  input logic              outValid,
  input logic              outFrameEnd
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R6: valid emerges three edges after it enters
  a_r6_fixed_latency: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R3: reads are always on word boundaries
  a_r3_word_step: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (rdAddr[1:0] == 2'b00));

  // R8: no reads while the frame is in error
  a_r8_quiet_after_error: assert property (@(posedge clk) disable iff (!rstN)
    errStatus |-> !rdReq);

  // R10: the flag only drops with the frame-end pixel
  a_r10_clear_at_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errStatus) |-> (outValid && outFrameEnd));
endmodule

bind pixfix_top pixfix_checker #(.ADDR_W(ADDR_W)) uChecker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .rdReq(rdReq), .rdAddr(rdAddr),
  .errStatus(errStatus), .outValid(outValid), .outFrameEnd(outFrameEnd)
);

// File: tb/test_pixfix_top.sv
`timescale 1ns/1ps
module test_pixfix_top;
  localparam int W = 8;
  localparam int H = 4;
  localparam int ND = 6;
  localparam int MAXV = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0;
  logic [14:0] cfgCount = '0;
  logic [31:0] cfgBase = '0;
  logic        inValid = 1'b0;
  logic [9:0]  inPix = '0;
  logic        inFrameStart = 1'b0, inLineStart = 1'b0, inLineEnd = 1'b0, inFrameEnd = 1'b0;
  logic        rdReq;
  logic [31:0] rdAddr;
  logic        rdReady = 1'b1;
  logic        rdValid = 1'b0;
  logic [31:0] rdData = '0;
  logic        outValid;
  logic [9:0]  outPix;
  logic        outFrameStart, outLineStart, outLineEnd, outFrameEnd;
  logic        errStatus;

  pixfix_top i_pixfix_top (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgCount(cfgCount), .cfgBase(cfgBase),
    .inValid(inValid), .inPix(inPix), .inFrameStart(inFrameStart), .inLineStart(inLineStart),
    .inLineEnd(inLineEnd), .inFrameEnd(inFrameEnd),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdReady(rdReady), .rdValid(rdValid), .rdData(rdData),
    .outValid(outValid), .outPix(outPix), .outFrameStart(outFrameStart),
    .outLineStart(outLineStart), .outLineEnd(outLineEnd), .outFrameEnd(outFrameEnd),
    .errStatus(errStatus)
  );

  always #10 clk = ~clk;

  int vectors = 0, miscompares = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int dRow [ND] = '{0, 0, 1, 2, 2, 3};
  int dCol [ND] = '{0, 7, 3, 1, 6, 4};
  logic [31:0] frameBase [5] = '{32'h1000_0027, 32'h0, 32'h3000_0011, 32'h1000_0027, 32'h2000_003C};
  int expReqs [5] = '{6, 0, 3, 0, 6};

  logic [9:0] expPix [MAXV];
  logic [3:0] expMark [MAXV];
  logic       expErr [MAXV];
  int         drvCyc [MAXV];
  string      expTag [MAXV];
  int drvIdx = 0, outIdx = 0;
  int epoch = 0, reqCount = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] rawPix(int f, int r, int c);
    return 10'((r * 53 + c * 29 + f * 71 + 17) % 1024);
  endfunction

  function automatic int findDefect(int r, int c);
    for (int k = 0; k < ND; k++) if (dRow[k] == r && dCol[k] == c) return k;
    return -1;
  endfunction

  // read responder: two-cycle latency, in order
  logic        p1Valid = 1'b0;
  logic [31:0] p1Data = '0;
  always @(posedge clk) begin
    rdValid <= p1Valid;
    rdData  <= p1Data;
    p1Valid <= 1'b0;
    if (rstN && rdReq && rdReady) begin
      automatic logic [31:0] aligned = frameBase[epoch] & ~32'd63;
      check(rdAddr == aligned + 32'(4 * reqCount), "R3", "read address",
            rdAddr, aligned + 32'(4 * reqCount));
      p1Valid <= 1'b1;
      p1Data  <= (reqCount < ND) ? {16'(dRow[reqCount]), 16'(dCol[reqCount])} : 32'hFFFF_FFFF;
      reqCount = reqCount + 1;
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (outIdx >= drvIdx) begin
        check(0, "R6", "unexpected output", outIdx, drvIdx);
      end else begin
        check(outPix == expPix[outIdx], expTag[outIdx], "pixel", outPix, expPix[outIdx]);
        check(({outFrameStart, outLineStart, outLineEnd, outFrameEnd} == expMark[outIdx]) &&
              (cyc - drvCyc[outIdx] == 3), "R6", "markers/latency",
              {outFrameStart, outLineStart, outLineEnd, outFrameEnd, 8'(cyc - drvCyc[outIdx])},
              {expMark[outIdx], 8'd3});
        check(errStatus == expErr[outIdx], expErr[outIdx] ? "R8" : "R10", "errStatus",
              errStatus, expErr[outIdx]);
        if (expErr[outIdx]) check(rdReq == 1'b0, "R8", "rdReq during error", rdReq, 0);
        if (outFrameEnd) begin
          check(reqCount == expReqs[epoch], "R2", "reads per frame", reqCount, expReqs[epoch]);
          reqCount = 0;
          if (epoch < 4) epoch = epoch + 1;
        end
      end
      outIdx++;
    end
  end

  task automatic setCfg(input bit en, input int cnt, input logic [31:0] base);
    @(negedge clk);
    cfgEnable = en;
    cfgCount  = 15'(cnt);
    cfgBase   = base;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 0; inFrameStart = 0; inLineStart = 0; inLineEnd = 0; inFrameEnd = 0;
    end
  endtask

  task automatic sendFrame(input int f, input bit en, input int cnt, input bit errFrame);
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        automatic int k = findDefect(r, c);
        automatic logic [9:0] v = rawPix(f, r, c);
        automatic string tag = "R4";
        @(negedge clk);
        inValid = 1; inPix = v;
        inFrameStart = (r == 0 && c == 0);
        inLineStart  = (c == 0);
        inLineEnd    = (c == W - 1);
        inFrameEnd   = (r == H - 1 && c == W - 1);
        if (!en) tag = "R1";
        else if (errFrame) tag = "R9";
        else if (k >= 0 && k < cnt) begin
          automatic bit hl = (c >= 2);
          automatic bit hr = (c + 2 <= W - 1);
          if (hl && hr) v = 10'((int'(rawPix(f, r, c - 2)) + int'(rawPix(f, r, c + 2))) / 2);
          else if (hl)  v = rawPix(f, r, c - 2);
          else          v = rawPix(f, r, c + 2);
          tag = (f == 5) ? "R10" : ((hl && hr) ? "R4" : "R5");
        end else if (k >= cnt) tag = "R2";
        expPix[drvIdx]  = v;
        expMark[drvIdx] = {inFrameStart, inLineStart, inLineEnd, inFrameEnd};
        expErr[drvIdx]  = errFrame && !(r == H - 1 && c == W - 1);
        expTag[drvIdx]  = tag;
        drvCyc[drvIdx]  = cyc;
        drvIdx++;
      end
      idle(2);
    end
  endtask

  initial begin
    setCfg(1, 6, frameBase[0]);
    repeat (4) @(negedge clk);
    check(outValid == 0 && errStatus == 0 && rdReq == 0, "R6", "reset state",
          {outValid, errStatus, rdReq}, 0);
    rstN = 1;
    idle(20);
    check(reqCount == 4 && rdReq == 0, "R7", "prefetch depth", {reqCount, 4'(rdReq)}, 32'h40);
    setCfg(0, 6, frameBase[1]);
    sendFrame(1, 1, 6, 0);
    idle(20);
    setCfg(1, 3, frameBase[2]);
    sendFrame(2, 0, 0, 0);
    idle(20);
    setCfg(1, 6, frameBase[3]);
    rdReady = 0;
    sendFrame(3, 1, 3, 0);
    idle(20);
    setCfg(1, 6, frameBase[4]);
    sendFrame(4, 1, 6, 1);
    idle(10);
    rdReady = 1;
    idle(20);
    sendFrame(5, 1, 6, 0);
    idle(20);
    check(outIdx == drvIdx, "R6", "output count", outIdx, drvIdx);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule